// File: doc/BRIEF.md
# Dual-Bus CAN Repeater Logic

This block is the digital core that sits between a protocol controller and two CAN bus transceiver sections. It takes a local transmit line, an expansion transmit line (used to chain several such cores into a wider bus tree), one enable per bus and the digitised comparator output of each bus. It produces a driver request per bus, a local receive line and an expansion receive line. Every line is active low: a low level is dominant, a high level is recessive.

A dominant level seen on either enabled bus is repeated onto the other bus, and either transmit input drives both buses. Neither bus has priority over the other. Without an extra measure, a dominant repeated onto one bus would be sensed there and sent back, so both buses would stay dominant for good. To prevent this, each bus's receiver is masked while the block drives that bus dominant. The mask is also held for a programmable number of clock cycles after the drive ends, so that the line has time to settle. All outputs are registered, one clock after their inputs.

Top module: `crep_dual_repeater`

## Requirements
- R1: All lines use 0 = dominant and 1 = recessive. A bus enable of 0 means enabled and 1 means disabled. Every output is registered and reflects the inputs sampled at the previous rising clock edge.
- R2: While `rst` is high, both driver requests and both receive outputs are 1 on the following clock, whatever the other inputs are.
- R3: A 0 on `tx_loc_n` or on `tx_exp_n` sets the driver request of every enabled bus to 0 on the next clock.
- R4: A 0 on the receive input of an enabled, unmasked bus sets the other bus's driver request to 0 (if that bus is enabled), and sets both `rx_loc_n` and `rx_exp_n` to 0 on the next clock.
- R5: `tx_loc_n` = 0 sets both `rx_loc_n` and `rx_exp_n` to 0. `tx_exp_n` = 0 sets only `rx_loc_n` to 0 and leaves `rx_exp_n` at 1. Both paths work with both buses disabled.
- R6: A disabled bus always has a driver request of 1, and its receive input changes no output.
- R7: While a bus's driver request is 0, that bus's receive input is ignored. A bus echoing the drive cannot keep the other bus or the receive outputs dominant.
- R8: When a bus's driver request returns to 1, its receive input stays ignored for `HOLD_CYC` more clock cycles. A dominant present in the cycle after that is relayed again.
- R9: A dominant received on a bus never sets that same bus's driver request to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| tx_loc_n | input | 1 | Local transmit line from the protocol controller, 0 = dominant |
| tx_exp_n | input | 1 | Expansion transmit line from a chained core, 0 = dominant |
| bus1_en_n | input | 1 | Bus 1 enable, 0 = enabled |
| bus2_en_n | input | 1 | Bus 2 enable, 0 = enabled |
| bus1_rx_n | input | 1 | Bus 1 comparator output, 0 = dominant |
| bus2_rx_n | input | 1 | Bus 2 comparator output, 0 = dominant |
| bus1_drv_n | output | 1 | Bus 1 driver request, 0 = drive dominant |
| bus2_drv_n | output | 1 | Bus 2 driver request, 0 = drive dominant |
| rx_loc_n | output | 1 | Local receive line to the protocol controller |
| rx_exp_n | output | 1 | Expansion receive line to a chained core |

## Verification
The bench builds the block with `HOLD_CYC` = 3. This keeps the release window short enough that a dominant held through the whole window can be checked cycle by cycle. That check confirms the window is ignored for exactly three cycles and that relaying resumes on the fourth. With the short window, one run can also cover an echo on the driven bus, a drive that moves from one bus to the other, and the direct and disabled-bus paths.

// File: rtl/crep_pkg.sv
package crep_pkg;

    localparam int NUM_BUS = 2;

    typedef logic [NUM_BUS-1:0] bus_vec_t;

    // Transmit-side requests, active high (1 = dominant requested)
    typedef struct packed {
        logic loc;
        logic exp;
    } tx_dom_t;

    // Receive-side results, active high (1 = dominant reported)
    typedef struct packed {
        logic loc;
        logic exp;
    } rx_dom_t;

    // Convert an active-low line level to an active-high dominant flag
    function automatic logic to_dom(input logic line_n);
        return ~line_n;
    endfunction

    // Convert an active-high dominant flag back to an active-low line level
    function automatic logic to_line(input logic is_dom);
        return ~is_dom;
    endfunction

    // Counter width needed to hold a release delay
    function automatic int hold_width(input int hold_cyc);
        return (hold_cyc < 1) ? 1 : $clog2(hold_cyc + 1);
    endfunction

endpackage

// File: rtl/crep_bus_lane.sv
module crep_bus_lane
    import crep_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    input  logic rx_n,
    input  logic relay_dom,
    output logic rcv_dom,
    output logic drv_n
);

    localparam int CW = hold_width(HOLD_CYC);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);
    localparam logic [CW-1:0] ONE     = CW'(1);

    logic          enabled;
    logic          drv_q;
    logic [CW-1:0] hold_q;
    logic          masked;

    assign enabled = ~en_n;

    // Feedback suppression: blind while driving and while the release timer runs
    assign masked  = drv_q | (hold_q != '0);
    assign rcv_dom = enabled & to_dom(rx_n) & ~masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            drv_q <= enabled & relay_dom;
            if (drv_q) begin
                hold_q <= HOLD_LD;
            end else if (hold_q != '0) begin
                hold_q <= hold_q - ONE;
            end
        end
    end

    assign drv_n = to_line(drv_q);

    AST_DIS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        en_n |=> drv_n); // R6

    generate
        if (HOLD_CYC > 0) begin : g_hold_chk
            AST_MASK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
                $rose(drv_n) |-> !rcv_dom); // R8
        end
    endgenerate

endmodule

// File: rtl/crep_relay_core.sv
module crep_relay_core
    import crep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tx_dom_t  tx_dom,
    input  bus_vec_t rcv_dom,
    output bus_vec_t relay_dom,
    output logic     rx_loc_n,
    output logic     rx_exp_n
);

    logic    tx_any;
    logic    rcv_any;
    rx_dom_t rx_d;
    rx_dom_t rx_q;

    assign tx_any  = tx_dom.loc | tx_dom.exp;
    assign rcv_any = |rcv_dom;

    // Each bus is driven by the transmit lines and by every bus except itself
    generate
        for (genvar k = 0; k < NUM_BUS; k++) begin : g_relay
            localparam bus_vec_t SELF = bus_vec_t'(1) << k;
            assign relay_dom[k] = tx_any | (|(rcv_dom & ~SELF));
        end
    endgenerate

    // Local line sees both transmit inputs; expansion line only the local one
    always_comb begin
        rx_d.loc = tx_any | rcv_any;
        rx_d.exp = tx_dom.loc | rcv_any;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_loc_n = to_line(rx_q.loc);
    assign rx_exp_n = to_line(rx_q.exp);

endmodule

// File: rtl/crep_dual_repeater.sv
module crep_dual_repeater
    import crep_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_loc_n,
    input  logic tx_exp_n,
    input  logic bus1_en_n,
    input  logic bus2_en_n,
    input  logic bus1_rx_n,
    input  logic bus2_rx_n,
    output logic bus1_drv_n,
    output logic bus2_drv_n,
    output logic rx_loc_n,
    output logic rx_exp_n
);

    tx_dom_t  tx_dom;
    bus_vec_t en_vec_n;
    bus_vec_t rx_vec_n;
    bus_vec_t drv_vec_n;
    bus_vec_t rcv_dom;
    bus_vec_t relay_dom;

    assign tx_dom.loc = to_dom(tx_loc_n);
    assign tx_dom.exp = to_dom(tx_exp_n);
    assign en_vec_n   = {bus2_en_n, bus1_en_n};
    assign rx_vec_n   = {bus2_rx_n, bus1_rx_n};

    generate
        for (genvar k = 0; k < NUM_BUS; k++) begin : g_lane
            crep_bus_lane #(
                .HOLD_CYC (HOLD_CYC)
            ) u_lane (
                .clk       (clk),
                .rst       (rst),
                .en_n      (en_vec_n[k]),
                .rx_n      (rx_vec_n[k]),
                .relay_dom (relay_dom[k]),
                .rcv_dom   (rcv_dom[k]),
                .drv_n     (drv_vec_n[k])
            );
        end
    endgenerate

    crep_relay_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tx_dom    (tx_dom),
        .rcv_dom   (rcv_dom),
        .relay_dom (relay_dom),
        .rx_loc_n  (rx_loc_n),
        .rx_exp_n  (rx_exp_n)
    );

    assign bus1_drv_n = drv_vec_n[0];
    assign bus2_drv_n = drv_vec_n[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (bus1_drv_n && bus2_drv_n && rx_loc_n && rx_exp_n)); // R2

    AST_TX_BOTH_BUSES: assert property (@(posedge clk) disable iff (rst)
        ((!tx_loc_n || !tx_exp_n) && !bus1_en_n && !bus2_en_n)
            |=> (!bus1_drv_n && !bus2_drv_n)); // R3

    AST_TX_LOC_DIRECT: assert property (@(posedge clk) disable iff (rst)
        !tx_loc_n |=> (!rx_loc_n && !rx_exp_n)); // R5

endmodule

// File: tb/crep_dual_repeater_bench.sv
`timescale 1ns/1ps
module crep_dual_repeater_bench;

    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_loc_n = 1'b1, tx_exp_n = 1'b1;
    logic bus1_en_n = 1'b1, bus2_en_n = 1'b1;
    logic bus1_rx_n = 1'b1, bus2_rx_n = 1'b1;
    logic bus1_drv_n, bus2_drv_n, rx_loc_n, rx_exp_n;

    always #2.5 clk = ~clk;

    crep_dual_repeater #(.HOLD_CYC(HOLD)) u_crep_dual_repeater (
        .clk(clk), .rst(rst),
        .tx_loc_n(tx_loc_n), .tx_exp_n(tx_exp_n),
        .bus1_en_n(bus1_en_n), .bus2_en_n(bus2_en_n),
        .bus1_rx_n(bus1_rx_n), .bus2_rx_n(bus2_rx_n),
        .bus1_drv_n(bus1_drv_n), .bus2_drv_n(bus2_drv_n),
        .rx_loc_n(rx_loc_n), .rx_exp_n(rx_exp_n)
    );

    typedef struct {
        int         stamp;
        logic [3:0] expv;   // {bus1_drv_n, bus2_drv_n, rx_loc_n, rx_exp_n}
        string      tag;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: apply one input vector per cycle and queue its expected result
    task automatic apply(input logic r, input logic tl, input logic te,
                         input logic e1, input logic e2,
                         input logic b1, input logic b2,
                         input logic [3:0] expv, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        rst = r; tx_loc_n = tl; tx_exp_n = te;
        bus1_en_n = e1; bus2_en_n = e2;
        bus1_rx_n = b1; bus2_rx_n = b2;
        it.stamp = cyc;
        it.expv  = expv;
        it.tag   = tag;
        sbq.push_back(it);
    endtask

    // Monitor: results appear one edge after the vector was applied
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0 && sbq[0].stamp < cyc) begin
                item_t it;
                logic [3:0] got;
                it  = sbq.pop_front();
                got = {bus1_drv_n, bus2_drv_n, rx_loc_n, rx_exp_n};
                n_vec++;
                if (got !== it.expv) begin
                    n_bad++;
                    $display("FAIL %s: got %b expected %b", it.tag, got, it.expv);
                end
            end
        end
    end

    initial begin
        // reset holds everything recessive regardless of inputs
        apply(1, 0,1,0,0,0,1, 4'b1111, "R2 reset with tx and bus1 dominant");
        apply(1, 1,0,0,0,1,0, 4'b1111, "R2 reset with text and bus2 dominant");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle recessive");
        apply(0, 0,1,0,0,1,1, 4'b0000, "R3 R5 local tx drives both buses and both rx");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 release after local tx");
        // bus1 echo inside release window is ignored for HOLD cycles
        apply(0, 1,1,0,0,0,1, 4'b1111, "R8 window cycle 1");
        apply(0, 1,1,0,0,0,1, 4'b1111, "R8 window cycle 2");
        apply(0, 1,1,0,0,0,1, 4'b1111, "R8 window cycle 3");
        apply(0, 1,1,0,0,0,1, 4'b1000, "R8 R4 bus1 relayed after window");
        apply(0, 1,1,0,0,0,1, 4'b1000, "R9 bus1 not driven by itself");
        apply(0, 1,1,0,0,0,0, 4'b1000, "R7 bus2 echo ignored while driven");
        apply(0, 1,1,0,0,1,0, 4'b1111, "R7 bus2 echo alone no latch");
        apply(0, 1,1,0,0,1,0, 4'b1111, "R8 bus2 echo in window");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        // symmetric direction: bus2 node relayed to bus1
        apply(0, 1,1,0,0,1,0, 4'b0100, "R4 R9 bus2 relayed to bus1 only");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle after bus2");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        // direct paths with both buses disabled
        apply(0, 1,0,1,1,1,1, 4'b1101, "R5 R6 text to rx_loc only, buses off");
        apply(0, 0,1,1,1,1,1, 4'b1100, "R5 R6 tx to both rx, buses off");
        apply(0, 1,1,1,0,0,1, 4'b1111, "R6 disabled bus1 receive ignored");
        apply(0, 1,0,0,1,1,1, 4'b0101, "R3 R6 text drives enabled bus1 only");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        apply(0, 1,0,0,0,1,1, 4'b0001, "R3 R5 text drives both buses");
        apply(0, 1,1,0,0,1,1, 4'b1111, "R1 idle");
        repeat (3) @(posedge clk);
        wait (sbq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule